// File: doc/BRIEF.md
# Serial Bus Address Arbitration Unit

This unit decides which of several controllers may use a shared open-drain serial line. Each frame carries one arbitration octet. Inside that octet, a free/occupied flag tells every listener whether some controller already holds the line. A short address field then settles any contention. The line is a wired-AND: any device that pulls the line low forces it to read 0, and a released line reads 1.

A device with a pending request waits for a frame whose flag reads free. It then sends its 3-bit address one bit at a time and reads back each bit from the line. If the device releases the line for a 1 and reads back 0, a contender with a lower address is present. The device stops driving at once. The device that completes its address without a mismatch takes the grant within that frame. In every later frame it holds the flag at occupied, until its request goes away.

The request comes from either of two sources: a software flag or a frame-ready signal from a packet transmitter. A device that loses keeps its request and tries again at the next frame that shows the line free. The line is read on the rising bit-clock edge. The pull-down enable is registered on that same edge, so it holds steady for the whole next bit.

Top module: `serial_bus_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising edge, `grant` and `line_pull` are 0 after that edge.
- R2: A requesting device that is not the owner reads the flag as 0 at frame position OCT_POS+2 (octet bit 5, default position 26). It then pulls the line low nowhere in that frame's address field and gains no grant in that frame.
- R3: A device that reads the flag as 1 and has a request sends its address in frame positions OCT_POS+5..OCT_POS+7 (default 29, 30, 31), carrying address bits 2, 1 and 0 in that order. For a 0 bit it pulls the line low (`line_pull`=1); for a 1 bit it releases the line.
- R4: After a released 1 bit reads back as 0, the device pulls the line low for none of the remaining address bits and gets no grant in that frame.
- R5: When two devices with distinct addresses contend in the same frame, only the device with the numerically lower address gets the grant.
- R6: `grant` rises on the edge that ends the last address bit of the winning frame, and not earlier.
- R7: An owner whose request is still held pulls the line low at the flag position of every later frame, and at no other position.
- R8: When both request inputs are 0 at an edge, `grant` is 0 after that edge, and the line is no longer pulled at the next flag position.
- R9: A device that lost does not contend while the flag reads 0. It contends again, with its request still held, in the first frame whose flag reads 1.
- R10: `sw_req` alone and `pkt_req` alone each count as a request.
- R11: With no request held and no grant, `line_pull` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; the line is read and the drive is updated on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_sync | input | 1 | High during bit position 0 of each frame |
| line_in | input | 1 | Value read from the shared line in the current bit |
| sw_req | input | 1 | Request flag set by software |
| pkt_req | input | 1 | Request from the packet transmitter that has a frame ready |
| my_addr | input | ADDR_W | This device's arbitration address |
| line_pull | output | 1 | Open-drain enable; 1 pulls the line low during the current bit |
| grant | output | 1 | The line is owned by this device |

## Verification
The assertions assume the following about the inputs. `frame_sync` arrives every FRAME_BITS cycles. `my_addr` stays stable while a request is held. No two contenders share an address. `line_in` is the wired-AND of every driver in the same bit. The bench meets these assumptions. It pulses the sync once per frame and changes requests and addresses only in a spare cycle between frames. It builds the line value as the AND of the device's release and a behavioural peer's release. The sweep covers all 56 pairs of distinct addresses, plus each address contending alone.

// File: rtl/sba_pkg.sv
// Shared types for the serial bus arbitration unit.
// Assumes nothing beyond being compiled ahead of the modules that use it.
package sba_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONTEND = 2'd1,
        ST_OWNER   = 2'd2
    } sba_state_e;
endpackage

// File: rtl/sba_bit_counter.sv
// Frame bit-position tracker.
// Reports the position of the current bit and of the next bit. Position 0 is
// the cycle in which frame_sync is high. Assumes frame_sync pulses once every
// FRAME_BITS cycles. Positions are flagged invalid until the first sync is seen.
module sba_bit_counter #(
    parameter int FRAME_BITS = 32,
    parameter int PW         = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_sync,
    output logic [PW-1:0] cur_pos,
    output logic [PW-1:0] next_pos,
    output logic          pos_valid
);
    localparam logic [PW-1:0] LAST_P = PW'(FRAME_BITS - 1);

    logic [PW-1:0] pos_q;
    logic          synced_q;

    // Current and following bit position; a sync forces position 0.
    always_comb begin
        cur_pos   = frame_sync ? '0 : pos_q;
        next_pos  = (cur_pos == LAST_P) ? '0 : cur_pos + 1'b1;
        pos_valid = synced_q | frame_sync;
    end

    // Advance the position and remember that a frame boundary was seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            synced_q <= 1'b0;
        end else begin
            pos_q    <= next_pos;
            synced_q <= synced_q | frame_sync;
        end
    end
endmodule

// File: rtl/sba_arb_core.sv
// Arbitration state machine and open-drain drive.
// At the flag position it reads whether the line is free. It then sends the
// address most significant bit first, compares each bit with the line,
// withdraws on a mismatch, and keeps the flag at occupied while it owns the line.
// Assumes regular frames, a stable address while requesting, and a wired-AND
// line_in. The drive is registered, so it holds through the whole next bit.
module sba_arb_core
    import sba_pkg::*;
#(
    parameter int FRAME_BITS = 32,
    parameter int OCT_POS    = 24,
    parameter int ADDR_W     = 3,
    parameter int PW         = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pos_valid,
    input  logic [PW-1:0]     cur_pos,
    input  logic [PW-1:0]     next_pos,
    input  logic              line_in,
    input  logic              req,
    input  logic [ADDR_W-1:0] my_addr,
    output logic              line_pull,
    output logic              grant
);
    localparam int            FLAG_BIT     = 5;
    localparam int            IW           = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
    localparam logic [PW-1:0] FLAG_P       = PW'(OCT_POS + 7 - FLAG_BIT);
    localparam logic [PW-1:0] ADDR_FIRST_P = PW'(OCT_POS + 8 - ADDR_W);
    localparam logic [PW-1:0] ADDR_LAST_P  = PW'(OCT_POS + 7);

    sba_state_e    state_q, state_d;
    logic          pull_q, pull_d;
    logic          cur_in_addr, next_in_addr, cur_bit, next_bit;
    logic [IW-1:0] cur_idx, next_idx;

    // Locate the current and next bit inside the address field.
    always_comb begin
        cur_in_addr  = (cur_pos >= ADDR_FIRST_P) && (cur_pos <= ADDR_LAST_P);
        next_in_addr = (next_pos >= ADDR_FIRST_P) && (next_pos <= ADDR_LAST_P);
        cur_idx      = IW'(ADDR_LAST_P - cur_pos);
        next_idx     = IW'(ADDR_LAST_P - next_pos);
        cur_bit      = my_addr[cur_idx];
        next_bit     = my_addr[next_idx];
    end

    // Next arbitration state from the line value read in this bit.
    always_comb begin
        state_d = state_q;
        if (!req) begin
            state_d = ST_IDLE;
        end else if (pos_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cur_pos == FLAG_P && line_in) state_d = ST_CONTEND;
                end
                ST_CONTEND: begin
                    if (cur_in_addr) begin
                        if (cur_bit && !line_in)        state_d = ST_IDLE;
                        else if (cur_pos == ADDR_LAST_P) state_d = ST_OWNER;
                    end
                end
                ST_OWNER: state_d = ST_OWNER;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Pull-down for the next bit: the flag when owning, zero address bits when contending.
    always_comb begin
        pull_d = 1'b0;
        if (pos_valid) begin
            if (state_d == ST_OWNER && next_pos == FLAG_P)                 pull_d = 1'b1;
            if (state_d == ST_CONTEND && next_in_addr && !next_bit)        pull_d = 1'b1;
        end
    end

    // State and drive registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pull_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pull_q  <= pull_d;
        end
    end

    assign line_pull = pull_q;
    assign grant     = (state_q == ST_OWNER);

    assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_valid && req && !grant && cur_pos == FLAG_P && !line_in)
        |=> (!line_pull && state_q == ST_IDLE));

    assert_contend_pulls_zero_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pull && !grant) |-> (cur_in_addr && !cur_bit));

    assert_loss_withdraws_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_valid && state_q == ST_CONTEND && cur_in_addr && cur_bit && !line_in)
        |=> (!grant && !line_pull));

    assert_grant_at_last_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> ($past(cur_pos) == ADDR_LAST_P));

    assert_flag_only_by_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pull && cur_pos == FLAG_P) |-> grant);

    assert_release_on_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!grant && !line_pull));

    assert_quiet_without_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !grant) |=> !line_pull);
endmodule

// File: rtl/serial_bus_arbiter.sv
// Top of the serial bus arbitration unit.
// Merges the two request sources and connects the position tracker to the
// arbitration core. Assumes OCT_POS + 7 < FRAME_BITS and ADDR_W <= 5, so that
// the address field lies after the flag bit.
module serial_bus_arbiter #(
    parameter int FRAME_BITS = 32,
    parameter int OCT_POS    = 24,
    parameter int ADDR_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              line_in,
    input  logic              sw_req,
    input  logic              pkt_req,
    input  logic [ADDR_W-1:0] my_addr,
    output logic              line_pull,
    output logic              grant
);
    localparam int PW = $clog2(FRAME_BITS);

    logic [PW-1:0] cur_pos, next_pos;
    logic          pos_valid;
    logic          req;

    // Either source counts as a request.
    assign req = sw_req | pkt_req;

    sba_bit_counter #(.FRAME_BITS(FRAME_BITS), .PW(PW)) u_pos (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .cur_pos(cur_pos), .next_pos(next_pos), .pos_valid(pos_valid)
    );

    sba_arb_core #(.FRAME_BITS(FRAME_BITS), .OCT_POS(OCT_POS), .ADDR_W(ADDR_W), .PW(PW)) u_core (
        .clk(clk), .rst_n(rst_n), .pos_valid(pos_valid),
        .cur_pos(cur_pos), .next_pos(next_pos), .line_in(line_in),
        .req(req), .my_addr(my_addr), .line_pull(line_pull), .grant(grant)
    );
endmodule

// File: tb/sim_serial_bus_arbiter.sv
`timescale 1ns/1ps
// Bench: the device under test shares a wired-AND line with a behavioural peer.
module sim_serial_bus_arbiter;
    localparam int FLAG = 26;
    localparam int ALAST = 31;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic       sw_req = 1'b0, pkt_req = 1'b0;
    logic [2:0] my_addr = 3'd0;
    logic       peer_pull = 1'b0;
    logic       dut_pull, grant;
    wire        line = ~(dut_pull | peer_pull);

    logic       peer_req = 1'b0;
    logic [2:0] peer_addr = 3'd0;
    int         peer_st = 0;
    logic [31:0] rec_mask;
    logic       grant_last;
    int         checks = 0, failures = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    serial_bus_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .line_in(line),
        .sw_req(sw_req), .pkt_req(pkt_req), .my_addr(my_addr),
        .line_pull(dut_pull), .grant(grant)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected pull mask of a contending device, and whether it wins.
    function automatic logic [31:0] exp_mask(input logic [2:0] a, input bit peer_on,
                                            input logic [2:0] b, output bit won);
        logic [31:0] m = '0;
        bit alive = 1'b1, pa = peer_on;
        for (int i = 2; i >= 0; i--) begin
            if (alive) begin
                if (!a[i]) m[ALAST - i] = 1'b1;
                else if (pa && !b[i]) alive = 1'b0;
                if (pa && b[i] && !a[i]) pa = 1'b0;
            end
        end
        won = alive;
        return m;
    endfunction

    // One frame: the peer model drives its bits; the device's pulls are recorded.
    task automatic run_frame();
        bit lv;
        rec_mask = '0;
        for (int p = 0; p < 32; p++) begin
            @(negedge clk);
            frame_sync = (p == 0);
            peer_pull = (peer_st == 2 && p == FLAG) ||
                        (peer_st == 1 && p >= 29 && !peer_addr[ALAST - p]);
            #2;
            lv = line;
            rec_mask[p] = dut_pull;
            if (p == ALAST) grant_last = grant;
            if (!peer_req) peer_st = 0;
            else if (peer_st == 0) begin
                if (p == FLAG && lv) peer_st = 1;
            end else if (peer_st == 1 && p >= 29) begin
                if (peer_addr[ALAST - p] && !lv) peer_st = 0;
                else if (p == ALAST) peer_st = 2;
            end
        end
    endtask

    task automatic gap();
        @(negedge clk);
        frame_sync = 1'b0;
        peer_pull = 1'b0;
        #2;
    endtask

    initial begin
        bit won;
        logic [31:0] e;
        repeat (3) @(negedge clk);
        check(grant == 1'b0, "R1 reset grant", {31'd0, grant}, 32'd0);
        check(dut_pull == 1'b0, "R1 reset line", {31'd0, dut_pull}, 32'd0);
        rst_n = 1'b1;

        // No request: no drive.
        run_frame(); run_frame();
        check(rec_mask == 32'd0, "R11 idle mask", rec_mask, 32'd0);
        gap();
        check(grant == 1'b0, "R11 idle grant", {31'd0, grant}, 32'd0);

        // Each address alone: send, win, hold flag, release.
        for (int a = 0; a < 8; a++) begin
            my_addr = 3'(a); sw_req = 1'b1;
            run_frame();
            e = exp_mask(3'(a), 1'b0, 3'd0, won);
            check(rec_mask == e, "R3 alone address bits", rec_mask, e);
            check(grant_last == 1'b0, "R6 no grant before last bit", {31'd0, grant_last}, 32'd0);
            gap();
            check(grant == 1'b1, "R6 grant after winning frame", {31'd0, grant}, 32'd1);
            run_frame();
            check(rec_mask == (32'd1 << FLAG), "R7 owner holds flag", rec_mask, 32'd1 << FLAG);
            gap();
            sw_req = 1'b0;
            run_frame();
            check(rec_mask == 32'd0, "R8 flag released", rec_mask, 32'd0);
            gap();
            check(grant == 1'b0, "R8 grant dropped", {31'd0, grant}, 32'd0);
        end

        // Every pair of distinct addresses against the peer.
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                if (a != b) begin
                    my_addr = 3'(a); peer_addr = 3'(b); peer_req = 1'b1;
                    if (a % 2 == 1) pkt_req = 1'b1; else sw_req = 1'b1;
                    run_frame();
                    e = exp_mask(3'(a), 1'b1, 3'(b), won);
                    check(rec_mask == e, "R4 contention pulls", rec_mask, e);
                    gap();
                    check(grant == won && won == (a < b), "R5 R10 lowest wins",
                          {31'd0, grant}, {31'd0, (a < b)});
                    if (!won) begin
                        run_frame();
                        check(rec_mask == 32'd0, "R2 busy frame quiet", rec_mask, 32'd0);
                        gap();
                        check(grant == 1'b0, "R2 busy no grant", {31'd0, grant}, 32'd0);
                        peer_req = 1'b0;
                        run_frame();
                        e = exp_mask(3'(a), 1'b0, 3'd0, won);
                        check(rec_mask == e, "R9 retry pulls", rec_mask, e);
                        gap();
                        check(grant == 1'b1, "R9 retry wins", {31'd0, grant}, 32'd1);
                    end
                    sw_req = 1'b0; pkt_req = 1'b0; peer_req = 1'b0;
                    run_frame();
                    gap();
                    peer_st = 0;
                end
            end
        end

        // Reset while owning.
        my_addr = 3'd3; sw_req = 1'b1;
        run_frame(); gap();
        check(grant == 1'b1, "R6 grant before reset", {31'd0, grant}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check(grant == 1'b0 && dut_pull == 1'b0, "R1 reset while owner",
              {30'd0, grant, dut_pull}, 32'd0);
        rst_n = 1'b1; sw_req = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule